// File: doc/BRIEF.md
# Multi-Layer Road Linker

The road linker takes one event's worth of pixel hits from four detector layers and turns them into track candidates. Each layer presents a vector of pixels, and each pixel carries a small slope class. The linker scans a table of roads that software has loaded beforehand. A road names one required pixel in every layer, plus an expected slope class per layer and the momentum and phi codes to report for that road.

A road fires when the number of layers that do not satisfy it is no larger than a programmable miss allowance. A layer satisfies a road when the required pixel is lit. When slope checking is switched on, the pixel's slope class must also equal the road's. Firing roads are sent out as track words on a valid/ready stream, in ascending table order. The number of tracks per event is capped, and matches beyond the cap are discarded. Every event closes with an end-of-event word that reports whether the cap was reached.

Only roads above the momentum threshold are meant to be loaded, so every road in the table is reportable. The table is loaded through an address/data write port, and each entry carries its own valid bit.

Top module: `road_linker`

## Requirements
- R1: After reset `outValid` and `busy` are low and every table entry is invalid, so an event loaded before any table write yields only the end word.
- R2: For each valid road the miss count is the number of layers whose required pixel is not lit. The road fires when this count is less than or equal to the miss allowance (0 to 3). `wrPix` holds one pixel index per layer, with layer 0 in the lowest bits. `layerPix` bit `l*PIX+p` is pixel p of layer l.
- R3: When `cfgSlopeEn` is 1, a lit pixel counts as a miss unless its slope class equals the road's slope class for that layer. The slope of pixel p of layer l is `layerSlope[(l*PIX+p)*SB +: SB]`, and `wrSlope` holds one class per layer with layer 0 lowest. When `cfgSlopeEn` is 0, slopes have no effect.
- R4: An entry written with `wrValid` = 0 never fires, whatever the pixels are.
- R5: Track words come out in ascending road index order. Each carries `outEnd` = 0, `outSat` = 0, the road index on `outRoad`, and that road's codes on `outPt` and `outPhi`.
- R6: After the last track of an event, exactly one word with `outEnd` = 1 follows, with `outRoad`, `outPt` and `outPhi` all zero. After it is accepted, `busy` falls.
- R7: At most MAXT tracks are sent per event, and further firing roads are dropped. `outSat` on the end word is 1 exactly when MAXT tracks were sent.
- R8: While `outValid` is high and `outReady` is low, the output word stays unchanged on the next cycle.
- R9: While `busy` is high, `evLoad`, table writes and configuration writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evLoad | input | 1 | Capture the layer inputs and start an event |
| layerPix | input | NL*PIX | Lit pixels of all layers |
| layerSlope | input | NL*PIX*SB | Slope class of every pixel |
| busy | output | 1 | Event in progress |
| wrEn | input | 1 | Table write strobe |
| wrAddr | input | RW | Road index to write |
| wrValid | input | 1 | Valid bit of the written entry |
| wrPix | input | NL*PIXW | Required pixel per layer |
| wrSlope | input | NL*SB | Required slope class per layer |
| wrPt | input | PTW | Momentum code of the road |
| wrPhi | input | PHW | Phi code of the road |
| cfgWe | input | 1 | Configuration write strobe |
| cfgMissAllow | input | AW | Tolerated missing layers |
| cfgSlopeEn | input | 1 | Require slope agreement |
| outValid | output | 1 | Output word valid |
| outReady | input | 1 | Consumer accepts the word |
| outEnd | output | 1 | End-of-event word |
| outSat | output | 1 | Track cap reached (end word) |
| outRoad | output | RW | Road index of the track |
| outPt | output | PTW | Momentum code |
| outPhi | output | PHW | Phi code |

## Verification
The same event is replayed with the miss allowance set to 0, 1, 2 and 3. Roads present in four, three, two and one layers must then switch on one by one. A design that counts lit layers rather than missing ones, or that uses a strict comparison, drops or adds a road at the boundary. A road whose slope disagrees in one layer must fire only when slope checking is off or one miss is tolerated. An invalid entry that is fully lit must stay silent.

Several cap cases are run: an event that fires exactly the cap, one that fires below it, and one that fires above it. An off-by-one counter would then send one track too many or too few, or set the saturation flag wrongly. With the consumer stalled, the bench writes the table and configuration and pulses a second event load. A design that accepted any of these would corrupt the running event or change the result of the replay that follows.

// File: rtl/roadlink_pkg.sv
package roadlink_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SCAN,
    ST_END
  } linkState_e;

  typedef struct packed {
    logic capture;
    logic tableWe;
    logic cfgWe;
    logic emitEnd;
  } linkStrobe_t;

endpackage

// File: rtl/roadlink_datapath.sv
module roadlink_datapath
  import roadlink_pkg::*;
#(
  parameter int NL  = 4,
  parameter int PIX = 16,
  parameter int SB  = 2,
  parameter int NR  = 32,
  parameter int PTW = 3,
  parameter int PHW = 6
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  linkStrobe_t            strb,
  input  logic [$clog2(NR)-1:0]  scanIdx,
  input  logic [NL*PIX-1:0]      layerPix,
  input  logic [NL*PIX*SB-1:0]   layerSlope,
  input  logic [$clog2(NR)-1:0]  wrAddr,
  input  logic                   wrValid,
  input  logic [NL*$clog2(PIX)-1:0] wrPix,
  input  logic [NL*SB-1:0]       wrSlope,
  input  logic [PTW-1:0]         wrPt,
  input  logic [PHW-1:0]         wrPhi,
  input  logic [$clog2(NL)-1:0]  cfgMissAllow,
  input  logic                   cfgSlopeEn,
  output logic                   roadFire,
  output logic [PTW-1:0]         trackPt,
  output logic [PHW-1:0]         trackPhi
);

  localparam int PIXW = $clog2(PIX);
  localparam int AW   = $clog2(NL);
  localparam int MCW  = $clog2(NL + 1);

  // road table
  logic              tValid [NR];
  logic [PIXW-1:0]   tPix   [NR][NL];
  logic [SB-1:0]     tSlope [NR][NL];
  logic [PTW-1:0]    tPt    [NR];
  logic [PHW-1:0]    tPhi   [NR];

  // captured event and configuration
  logic [PIX-1:0]    evPx [NL];
  logic [PIX*SB-1:0] evSl [NL];
  logic [AW-1:0]     missAllow;
  logic              slopeOn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int r = 0; r < NR; r++) tValid[r] <= 1'b0;
    end else if (strb.tableWe) begin
      tValid[wrAddr] <= wrValid;
      for (int l = 0; l < NL; l++) begin
        tPix[wrAddr][l]   <= wrPix[l*PIXW +: PIXW];
        tSlope[wrAddr][l] <= wrSlope[l*SB +: SB];
      end
      tPt[wrAddr]  <= wrPt;
      tPhi[wrAddr] <= wrPhi;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      missAllow <= '0;
      slopeOn   <= 1'b0;
    end else if (strb.cfgWe) begin
      missAllow <= cfgMissAllow;
      slopeOn   <= cfgSlopeEn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int l = 0; l < NL; l++) begin
        evPx[l] <= '0;
        evSl[l] <= '0;
      end
    end else if (strb.capture) begin
      for (int l = 0; l < NL; l++) begin
        evPx[l] <= layerPix[l*PIX +: PIX];
        evSl[l] <= layerSlope[l*PIX*SB +: PIX*SB];
      end
    end
  end

  // per-layer presence test for the road under scan
  logic [NL-1:0] present;

  generate
    for (genvar gl = 0; gl < NL; gl++) begin : g_layer
      logic [PIXW-1:0] reqPix;
      logic [SB-1:0]   reqSl;
      logic [SB-1:0]   gotSl;
      assign reqPix      = tPix[scanIdx][gl];
      assign reqSl       = tSlope[scanIdx][gl];
      assign gotSl       = evSl[gl][int'(reqPix)*SB +: SB];
      assign present[gl] = evPx[gl][reqPix] && (!slopeOn || (gotSl == reqSl));
    end
  endgenerate

  logic [MCW-1:0] missCnt;

  always_comb begin
    missCnt = '0;
    for (int l = 0; l < NL; l++) begin
      missCnt = missCnt + MCW'(!present[l]);
    end
  end

  assign roadFire = tValid[scanIdx] && (missCnt <= MCW'(missAllow));
  assign trackPt  = strb.emitEnd ? '0 : tPt[scanIdx];
  assign trackPhi = strb.emitEnd ? '0 : tPhi[scanIdx];

endmodule

// File: rtl/roadlink_ctrl.sv
module roadlink_ctrl
  import roadlink_pkg::*;
#(
  parameter int NR   = 32,
  parameter int MAXT = 288
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  evLoad,
  input  logic                  wrEn,
  input  logic                  cfgWe,
  input  logic                  roadFire,
  input  logic                  outReady,
  output linkStrobe_t           strb,
  output logic [$clog2(NR)-1:0] scanIdx,
  output logic                  outValid,
  output logic                  outEnd,
  output logic                  outSat,
  output logic [$clog2(NR)-1:0] outRoad,
  output logic                  busy
);

  localparam int RW = $clog2(NR);
  localparam int CW = $clog2(MAXT + 1);

  linkState_e    state;
  logic [RW-1:0] idx;
  logic [CW-1:0] trackCnt;
  logic          hit;
  logic          advance;
  logic          lastRoad;
  logic          idle;

  assign idle     = (state == ST_IDLE);
  assign hit      = (state == ST_SCAN) && roadFire && (trackCnt < CW'(MAXT));
  assign advance  = (state == ST_SCAN) && (!hit || outReady);
  assign lastRoad = (idx == RW'(NR - 1));

  always_comb begin
    strb.capture = evLoad && idle;
    strb.tableWe = wrEn && idle;
    strb.cfgWe   = cfgWe && idle;
    strb.emitEnd = (state == ST_END);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      idx      <= '0;
      trackCnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (evLoad) begin
            state    <= ST_SCAN;
            idx      <= '0;
            trackCnt <= '0;
          end
        end
        ST_SCAN: begin
          if (hit && outReady) trackCnt <= trackCnt + CW'(1);
          if (advance) begin
            if (lastRoad) state <= ST_END;
            else          idx   <= idx + RW'(1);
          end
        end
        ST_END: begin
          if (outReady) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign scanIdx  = idx;
  assign outValid = hit || (state == ST_END);
  assign outEnd   = (state == ST_END);
  assign outSat   = (state == ST_END) && (trackCnt == CW'(MAXT));
  assign outRoad  = (state == ST_END) ? '0 : idx;
  assign busy     = !idle;

endmodule

// File: rtl/road_linker.sv
module road_linker
  import roadlink_pkg::*;
#(
  parameter int NL   = 4,
  parameter int PIX  = 16,
  parameter int SB   = 2,
  parameter int NR   = 32,
  parameter int MAXT = 288,
  parameter int PTW  = 3,
  parameter int PHW  = 6,
  localparam int RW   = $clog2(NR),
  localparam int PIXW = $clog2(PIX),
  localparam int AW   = $clog2(NL)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 evLoad,
  input  logic [NL*PIX-1:0]    layerPix,
  input  logic [NL*PIX*SB-1:0] layerSlope,
  output logic                 busy,
  input  logic                 wrEn,
  input  logic [RW-1:0]        wrAddr,
  input  logic                 wrValid,
  input  logic [NL*PIXW-1:0]   wrPix,
  input  logic [NL*SB-1:0]     wrSlope,
  input  logic [PTW-1:0]       wrPt,
  input  logic [PHW-1:0]       wrPhi,
  input  logic                 cfgWe,
  input  logic [AW-1:0]        cfgMissAllow,
  input  logic                 cfgSlopeEn,
  output logic                 outValid,
  input  logic                 outReady,
  output logic                 outEnd,
  output logic                 outSat,
  output logic [RW-1:0]        outRoad,
  output logic [PTW-1:0]       outPt,
  output logic [PHW-1:0]       outPhi
);

  linkStrobe_t   strb;
  logic [RW-1:0] scanIdx;
  logic          roadFire;

  roadlink_ctrl #(.NR(NR), .MAXT(MAXT)) u_ctrl (
    .clk(clk), .rstN(rstN), .evLoad(evLoad), .wrEn(wrEn), .cfgWe(cfgWe),
    .roadFire(roadFire), .outReady(outReady), .strb(strb), .scanIdx(scanIdx),
    .outValid(outValid), .outEnd(outEnd), .outSat(outSat), .outRoad(outRoad),
    .busy(busy)
  );

  roadlink_datapath #(.NL(NL), .PIX(PIX), .SB(SB), .NR(NR), .PTW(PTW), .PHW(PHW)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .scanIdx(scanIdx),
    .layerPix(layerPix), .layerSlope(layerSlope),
    .wrAddr(wrAddr), .wrValid(wrValid), .wrPix(wrPix), .wrSlope(wrSlope),
    .wrPt(wrPt), .wrPhi(wrPhi), .cfgMissAllow(cfgMissAllow), .cfgSlopeEn(cfgSlopeEn),
    .roadFire(roadFire), .trackPt(outPt), .trackPhi(outPhi)
  );

endmodule

// File: rtl/road_linker_chk.sv
module road_linker_chk #(
  parameter int MAXT = 288,
  parameter int RW   = 5,
  parameter int PTW  = 3,
  parameter int PHW  = 6
) (
  input logic           clk,
  input logic           rstN,
  input logic           evLoad,
  input logic           busy,
  input logic           outValid,
  input logic           outReady,
  input logic           outEnd,
  input logic           outSat,
  input logic [RW-1:0]  outRoad,
  input logic [PTW-1:0] outPt,
  input logic [PHW-1:0] outPhi
);

  localparam int KW = $clog2(MAXT + 2);

  logic [KW-1:0] sentCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sentCnt <= '0;
    end else if (evLoad && !busy) begin
      sentCnt <= '0;
    end else if (outValid && outReady && !outEnd && (sentCnt <= KW'(MAXT))) begin
      sentCnt <= sentCnt + KW'(1);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    sentCnt <= KW'(MAXT)); // R7

  AST_SAT_ON_END: assert property (@(posedge clk) disable iff (!rstN)
    outSat |-> outEnd); // R7

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outEnd) && $stable(outRoad)
                                 && $stable(outPt) && $stable(outPhi))); // R8

  AST_END_TO_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && outEnd) |=> !busy); // R6

  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !outValid); // R1

  AST_END_FIELDS: assert property (@(posedge clk) disable iff (!rstN)
    outEnd |-> (outPt == '0 && outPhi == '0 && outRoad == '0)); // R6

endmodule

bind road_linker road_linker_chk #(
  .MAXT(MAXT), .RW($clog2(NR)), .PTW(PTW), .PHW(PHW)
) u_chk (
  .clk(clk), .rstN(rstN), .evLoad(evLoad), .busy(busy), .outValid(outValid),
  .outReady(outReady), .outEnd(outEnd), .outSat(outSat), .outRoad(outRoad),
  .outPt(outPt), .outPhi(outPhi)
);

// File: tb/road_linker_test.sv
`timescale 1ns/1ps
module road_linker_test;

  localparam int NL = 4, PIX = 16, SB = 2, NR = 16, MAXT = 4, PTW = 3, PHW = 6;

  typedef struct packed {
    logic       isEnd;
    logic       sat;
    logic [3:0] road;
    logic [2:0] pt;
    logic [5:0] phi;
  } item_t;

  logic clk = 0, rstN = 0;
  logic evLoad = 0;
  logic [NL*PIX-1:0] layerPix = '0;
  logic [NL*PIX*SB-1:0] layerSlope = '0;
  logic busy;
  logic wrEn = 0, wrValid = 0;
  logic [3:0] wrAddr = '0;
  logic [15:0] wrPix = '0;
  logic [7:0] wrSlope = '0;
  logic [2:0] wrPt = '0;
  logic [5:0] wrPhi = '0;
  logic cfgWe = 0, cfgSlopeEn = 0;
  logic [1:0] cfgMissAllow = '0;
  logic outValid, outReady = 0, outEnd, outSat;
  logic [3:0] outRoad;
  logic [2:0] outPt;
  logic [5:0] outPhi;

  road_linker #(.NL(NL), .PIX(PIX), .SB(SB), .NR(NR), .MAXT(MAXT), .PTW(PTW), .PHW(PHW)) uut (
    .clk(clk), .rstN(rstN), .evLoad(evLoad), .layerPix(layerPix), .layerSlope(layerSlope),
    .busy(busy), .wrEn(wrEn), .wrAddr(wrAddr), .wrValid(wrValid), .wrPix(wrPix),
    .wrSlope(wrSlope), .wrPt(wrPt), .wrPhi(wrPhi), .cfgWe(cfgWe), .cfgMissAllow(cfgMissAllow),
    .cfgSlopeEn(cfgSlopeEn), .outValid(outValid), .outReady(outReady), .outEnd(outEnd),
    .outSat(outSat), .outRoad(outRoad), .outPt(outPt), .outPhi(outPhi)
  );

  always #4 clk = ~clk;

  int checks = 0, fails = 0, endsSeen = 0, cyc = 0;
  bit holdReady = 0;
  bit done = 0;

  item_t expQ[$];
  string tagQ[$];

  bit shValid [NR];
  int shPix [NR][NL];
  int shSl  [NR][NL];
  int shPt [NR];
  int shPhi [NR];
  int curAllow = 0;
  bit curSlope = 0;

  logic [NL*PIX-1:0] evPixB;
  logic [NL*PIX*SB-1:0] evSlB;

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // ready pattern driver
  initial begin
    forever begin
      @(posedge clk); #1;
      cyc++;
      outReady = holdReady ? 1'b0 : ((cyc % 3) != 1);
    end
  end

  // monitor: compare accepted words against the scoreboard, check stalls
  item_t prevW;
  bit prevStall = 0;
  always @(negedge clk) begin
    if (rstN) begin
      item_t got;
      got = '{outEnd, outSat, outRoad, outPt, outPhi};
      if (prevStall) check(outValid && (got == prevW), "R8", "stalled word", int'(got), int'(prevW));
      prevStall = outValid && !outReady;
      prevW = got;
      if (outValid && outReady) begin
        if (expQ.size() == 0) begin
          check(0, "R5", "unexpected word", int'(got), 0);
        end else begin
          item_t e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          check(got == e, t, e.isEnd ? "end word" : "track word", int'(got), int'(e));
        end
        if (outEnd) endsSeen++;
      end
    end
  end

  task automatic writeRoad(int r, bit v, bit shadow);
    @(posedge clk); #1;
    wrEn = 1; wrAddr = 4'(r); wrValid = v;
    for (int l = 0; l < NL; l++) begin
      wrPix[l*4 +: 4] = 4'((r + 3*l) % 16);
      wrSlope[l*2 +: 2] = 2'((r + l) % 4);
    end
    wrPt = 3'(r % 8); wrPhi = 6'(r * 5);
    @(posedge clk); #1;
    wrEn = 0;
    if (shadow) begin
      shValid[r] = v;
      for (int l = 0; l < NL; l++) begin
        shPix[r][l] = (r + 3*l) % 16;
        shSl[r][l] = (r + l) % 4;
      end
      shPt[r] = r % 8; shPhi[r] = r * 5;
    end
  endtask

  task automatic setCfg(int allow, bit slope, bit shadow);
    @(posedge clk); #1;
    cfgWe = 1; cfgMissAllow = 2'(allow); cfgSlopeEn = slope;
    @(posedge clk); #1;
    cfgWe = 0;
    if (shadow) begin curAllow = allow; curSlope = slope; end
  endtask

  task automatic hitRoad(int r, int k, int badLayer);
    for (int l = 0; l < k; l++) begin
      int p;
      p = shPix[r][l];
      evPixB[l*PIX + p] = 1'b1;
      evSlB[(l*PIX + p)*SB +: SB] = (l == badLayer) ? 2'(shSl[r][l] ^ 1) : 2'(shSl[r][l]);
    end
  endtask

  task automatic predict(string tag);
    int n;
    n = 0;
    for (int r = 0; r < NR; r++) begin
      int miss;
      miss = 0;
      for (int l = 0; l < NL; l++) begin
        int p;
        bit pres;
        p = shPix[r][l];
        pres = evPixB[l*PIX + p] &&
               (!curSlope || (int'(evSlB[(l*PIX + p)*SB +: SB]) == shSl[r][l]));
        if (!pres) miss++;
      end
      if (shValid[r] && miss <= curAllow && n < MAXT) begin
        expQ.push_back('{1'b0, 1'b0, 4'(r), 3'(shPt[r]), 6'(shPhi[r])});
        tagQ.push_back(tag);
        n++;
      end
    end
    expQ.push_back('{1'b1, (n == MAXT), 4'd0, 3'd0, 6'd0});
    tagQ.push_back(tag);
  endtask

  task automatic startEvent(string tag);
    predict(tag);
    @(posedge clk); #1;
    evLoad = 1; layerPix = evPixB; layerSlope = evSlB;
    @(posedge clk); #1;
    evLoad = 0;
    check(busy === 1'b1, "R9", "busy after load", int'(busy), 1);
  endtask

  task automatic runEvent(string tag);
    int target;
    target = endsSeen + 1;
    startEvent(tag);
    wait (endsSeen == target);
    @(posedge clk); #1;
    check(busy === 1'b0, "R6", "busy after end", int'(busy), 0);
  endtask

  task automatic buildE1();
    evPixB = '0; evSlB = '0;
    hitRoad(1, 4, -1); hitRoad(2, 3, -1); hitRoad(4, 2, -1);
    hitRoad(6, 1, -1); hitRoad(5, 4, -1);
  endtask

  initial begin
    for (int r = 0; r < NR; r++) begin
      shValid[r] = 0; shPt[r] = 0; shPhi[r] = 0;
      for (int l = 0; l < NL; l++) begin shPix[r][l] = (r + 3*l) % 16; shSl[r][l] = 0; end
    end
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    @(negedge clk);
    check(outValid === 1'b0, "R1", "outValid after reset", int'(outValid), 0);
    check(busy === 1'b0, "R1", "busy after reset", int'(busy), 0);

    // R1: empty table, everything lit
    setCfg(3, 0, 1);
    evPixB = '1; evSlB = '0;
    runEvent("R1");

    for (int r = 0; r < 8; r++) writeRoad(r, (r != 5), 1);

    // R2 / R4 / R5: allowance sweep; road 5 is invalid but fully lit
    buildE1();
    setCfg(0, 0, 1); runEvent("R2");
    setCfg(1, 0, 1); runEvent("R4");
    setCfg(2, 0, 1); runEvent("R5");
    setCfg(3, 0, 1); runEvent("R7");   // exactly MAXT tracks -> sat

    // R3: slope mismatch in one layer of road 3
    evPixB = '0; evSlB = '0;
    hitRoad(1, 4, -1); hitRoad(3, 4, 2);
    setCfg(0, 1, 1); runEvent("R3");
    setCfg(1, 1, 1); runEvent("R3");
    setCfg(0, 0, 1); runEvent("R3");

    // R7: more firing roads than the cap
    evPixB = '1; evSlB = '0;
    setCfg(3, 0, 1); runEvent("R7");

    // R6: nothing lit
    evPixB = '0;
    setCfg(0, 0, 1); runEvent("R6");

    // R9: writes and loads while busy are ignored
    buildE1();
    setCfg(1, 0, 1);
    holdReady = 1;
    begin
      int target;
      target = endsSeen + 1;
      startEvent("R9");
      writeRoad(1, 0, 0);
      setCfg(0, 1, 0);
      @(posedge clk); #1;
      evLoad = 1; layerPix = '0;
      @(posedge clk); #1;
      evLoad = 0;
      check(busy === 1'b1, "R9", "busy during stall", int'(busy), 1);
      holdReady = 0;
      wait (endsSeen == target);
    end
    runEvent("R9");   // same table and allowance as before the ignored writes

    repeat (5) @(posedge clk);
    check(expQ.size() == 0, "R6", "scoreboard drained", expQ.size(), 0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R6 watchdog expired actual=%0d expected=%0d", endsSeen, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule